// File: doc/BRIEF.md
# Secondary Input Horizontal Conditioner

This block prepares the secondary pixel stream of a two-input display path before that stream reaches the blender. Pixels arrive one per accepted cycle as 32-bit RGBA words, together with a valid flag and start-of-line and start-of-frame markers. The block can work in one of three horizontal modes. In pass-through, every pixel goes straight through. In halving mode, the block averages neighbouring pixels in pairs and emits one pixel per pair. In doubling mode, the block emits every pixel twice and stalls its input for the cycle that carries the copy.

After any of these, four 4-bit channel masks can zero individual colour channels. The mask that applies to a pixel depends on the parity of that pixel's output row and output column. This suits checkerboard and line-interleaved layouts, where the views sit at alternate positions on the panel. The output is registered and has no backpressure.

Top module: `sec_hcond`

## Requirements
- R1: While reset is asserted, out_valid, out_sol and out_sof are low, out_pix is zero and in_ready is high.
- R2: With both mode enables low, each accepted pixel appears on the output in the next cycle with its markers unchanged.
- R3: With cfg_rep_en high, each accepted pixel is emitted on two consecutive cycles. The markers are carried only by the first copy.
- R4: With cfg_rep_en high, in_ready is low in the cycle after a pixel is accepted. When cfg_rep_en is low, in_ready is always high.
- R5: With cfg_lp_en high, accepted pixels are paired. One cycle after the second pixel of a pair is accepted, the block emits one pixel in which each 8-bit channel is (a+b+1)>>1. That pixel carries the markers of the first pixel of the pair.
- R6: In halving mode, a pixel carrying a start-of-line or start-of-frame marker always begins a new pair. An unpaired pixel that is still waiting at that moment is discarded.
- R7: When both mode enables are high, the block behaves exactly as doubling mode.
- R8: Each emitted pixel is masked by mask_ee, mask_eo, mask_oe or mask_oo, selected by (row even or odd, column even or odd) of its output position. Mask bit 3 zeroes out_pix[31:24] (R/Y), bit 2 zeroes [23:16] (G/U), bit 1 zeroes [15:8] (B/V) and bit 0 zeroes [7:0] (A).
- R9: Output coordinates count emitted pixels, after halving or doubling. A start-of-frame pixel is row 0, column 0. A start-of-line pixel is the next row, column 0. Any other pixel is the next column.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lp_en | input | 1 | Halving mode: pair averaging and 2:1 decimation |
| cfg_rep_en | input | 1 | Doubling mode: each pixel emitted twice (has priority) |
| mask_ee | input | 4 | Channel zero mask, even row and even column |
| mask_eo | input | 4 | Channel zero mask, even row and odd column |
| mask_oe | input | 4 | Channel zero mask, odd row and even column |
| mask_oo | input | 4 | Channel zero mask, odd row and odd column |
| in_valid | input | 1 | Input pixel present |
| in_sol | input | 1 | Input pixel starts a line |
| in_sof | input | 1 | Input pixel starts a frame |
| in_pix | input | 32 | Input RGBA pixel, R in the top byte |
| in_ready | output | 1 | Input pixel is taken this cycle when in_valid is high |
| out_valid | output | 1 | Output pixel present |
| out_sol | output | 1 | Output pixel starts a line |
| out_sof | output | 1 | Output pixel starts a frame |
| out_pix | output | 32 | Conditioned RGBA pixel |

## Verification
A pass-through pixel is due one clock after the edge that accepts it. An averaged pixel is due one clock after its second input is accepted. The first doubled copy is due one clock after acceptance and the second copy one clock later, and in_ready drops for exactly that second cycle. The bench keeps a queue of pixels that have been accepted but not yet shown. It pops one entry per clock, applies its own row and column counters and the masks to that entry, and compares the result at the falling edge with out_valid, the markers and out_pix. In the same step it predicts in_ready from the queue depth, so any latency slip or any extra or missing copy shows up in the first cycle it occurs.

// File: rtl/sec_hcond_pkg.sv
package sec_hcond_pkg;

    // Parity class of an output position: {row odd, column odd}
    typedef enum logic [1:0] {
        PAR_EE = 2'b00,
        PAR_EO = 2'b01,
        PAR_OE = 2'b10,
        PAR_OO = 2'b11
    } parity_e;

    function automatic parity_e parity_of(input logic row_odd, input logic col_odd);
        return parity_e'({row_odd, col_odd});
    endfunction

endpackage

// File: rtl/shc_pair_avg.sv
module shc_pair_avg #(
    parameter int CH_W  = 8,
    parameter int N_CH  = 4,
    localparam int PIX_W = CH_W * N_CH
) (
    input  logic [PIX_W-1:0] pix_a,
    input  logic [PIX_W-1:0] pix_b,
    output logic [PIX_W-1:0] pix_avg
);
    // Rounded mean per channel, computed one bit wider than a channel
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic [CH_W:0] sum;
        assign sum = {1'b0, pix_a[c*CH_W +: CH_W]} + {1'b0, pix_b[c*CH_W +: CH_W]} + {{CH_W{1'b0}}, 1'b1};
        assign pix_avg[c*CH_W +: CH_W] = sum[CH_W:1];
    end
endmodule

// File: rtl/shc_chan_mask.sv
module shc_chan_mask
    import sec_hcond_pkg::*;
#(
    parameter int CH_W  = 8,
    parameter int N_CH  = 4,
    localparam int PIX_W = CH_W * N_CH
) (
    input  logic [PIX_W-1:0] pix_i,
    input  logic             row_odd,
    input  logic             col_odd,
    input  logic [N_CH-1:0]  m_ee,
    input  logic [N_CH-1:0]  m_eo,
    input  logic [N_CH-1:0]  m_oe,
    input  logic [N_CH-1:0]  m_oo,
    output logic [PIX_W-1:0] pix_o
);
    logic [N_CH-1:0] sel;

    always_comb begin
        unique case (parity_of(row_odd, col_odd))
            PAR_EE:  sel = m_ee;
            PAR_EO:  sel = m_eo;
            PAR_OE:  sel = m_oe;
            default: sel = m_oo;
        endcase
    end

    // Mask bit c clears channel c; channel N_CH-1 is the top byte
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        assign pix_o[c*CH_W +: CH_W] = sel[c] ? '0 : pix_i[c*CH_W +: CH_W];
    end
endmodule

// File: rtl/shc_coord.sv
module shc_coord (
    input  logic emit,
    input  logic e_sol,
    input  logic e_sof,
    input  logic row_odd_q,
    input  logic col_odd_q,
    output logic row_odd_d,
    output logic col_odd_d
);
    // Only parity is ever consumed, so only parity is tracked
    always_comb begin
        row_odd_d = row_odd_q;
        col_odd_d = col_odd_q;
        if (emit) begin
            if (e_sof) begin
                row_odd_d = 1'b0;
                col_odd_d = 1'b0;
            end else if (e_sol) begin
                row_odd_d = ~row_odd_q;
                col_odd_d = 1'b0;
            end else begin
                col_odd_d = ~col_odd_q;
            end
        end
    end
endmodule

// File: rtl/sec_hcond.sv
module sec_hcond #(
    parameter int CH_W  = 8,
    parameter int N_CH  = 4,
    localparam int PIX_W = CH_W * N_CH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_lp_en,
    input  logic             cfg_rep_en,
    input  logic [N_CH-1:0]  mask_ee,
    input  logic [N_CH-1:0]  mask_eo,
    input  logic [N_CH-1:0]  mask_oe,
    input  logic [N_CH-1:0]  mask_oo,
    input  logic             in_valid,
    input  logic             in_sol,
    input  logic             in_sof,
    input  logic [PIX_W-1:0] in_pix,
    output logic             in_ready,
    output logic             out_valid,
    output logic             out_sol,
    output logic             out_sof,
    output logic [PIX_W-1:0] out_pix
);
    typedef struct packed {
        logic             hold;      // second copy of a doubled pixel owed
        logic             pend_vld;  // first pixel of a pair waiting
        logic             pend_sol;
        logic             pend_sof;
        logic [PIX_W-1:0] pend_pix;  // shared: pair head or doubled pixel
        logic             row_odd;
        logic             col_odd;
        logic             o_vld;
        logic             o_sol;
        logic             o_sof;
        logic [PIX_W-1:0] o_pix;
    } st_t;

    st_t s_d, s_q;

    logic             rep_mode, lp_mode, accept, brk;
    logic             emit, e_sol, e_sof;
    logic [PIX_W-1:0] e_pix, avg_pix, msk_pix;
    logic             row_nx, col_nx;

    assign rep_mode = cfg_rep_en;
    assign lp_mode  = cfg_lp_en & ~cfg_rep_en;
    assign in_ready = ~(rep_mode & s_q.hold);
    assign accept   = in_valid & in_ready;
    assign brk      = in_sol | in_sof;

    shc_pair_avg #(.CH_W(CH_W), .N_CH(N_CH)) u_avg (
        .pix_a   (s_q.pend_pix),
        .pix_b   (in_pix),
        .pix_avg (avg_pix)
    );

    // Which pixel, if any, leaves at the coming edge
    always_comb begin
        emit  = 1'b0;
        e_pix = in_pix;
        e_sol = in_sol;
        e_sof = in_sof;
        if (rep_mode && s_q.hold) begin
            emit  = 1'b1;
            e_pix = s_q.pend_pix;
            e_sol = 1'b0;
            e_sof = 1'b0;
        end else if (accept) begin
            if (lp_mode) begin
                if (s_q.pend_vld && !brk) begin
                    emit  = 1'b1;
                    e_pix = avg_pix;
                    e_sol = s_q.pend_sol;
                    e_sof = s_q.pend_sof;
                end
            end else begin
                emit = 1'b1;
            end
        end
    end

    shc_coord u_coord (
        .emit      (emit),
        .e_sol     (e_sol),
        .e_sof     (e_sof),
        .row_odd_q (s_q.row_odd),
        .col_odd_q (s_q.col_odd),
        .row_odd_d (row_nx),
        .col_odd_d (col_nx)
    );

    shc_chan_mask #(.CH_W(CH_W), .N_CH(N_CH)) u_mask (
        .pix_i   (e_pix),
        .row_odd (row_nx),
        .col_odd (col_nx),
        .m_ee    (mask_ee),
        .m_eo    (mask_eo),
        .m_oe    (mask_oe),
        .m_oo    (mask_oo),
        .pix_o   (msk_pix)
    );

    always_comb begin
        s_d         = s_q;
        s_d.row_odd = row_nx;
        s_d.col_odd = col_nx;
        s_d.o_vld   = emit;
        s_d.o_sol   = emit & e_sol;
        s_d.o_sof   = emit & e_sof;
        if (emit) begin
            s_d.o_pix = msk_pix;
        end

        s_d.hold = 1'b0;
        if (rep_mode && !s_q.hold && accept) begin
            s_d.hold     = 1'b1;
            s_d.pend_pix = in_pix;
        end

        if (!lp_mode) begin
            s_d.pend_vld = 1'b0;
        end else if (accept) begin
            if (s_q.pend_vld && !brk) begin
                s_d.pend_vld = 1'b0;
            end else begin
                s_d.pend_vld = 1'b1;
                s_d.pend_pix = in_pix;
                s_d.pend_sol = in_sol;
                s_d.pend_sof = in_sof;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_valid = s_q.o_vld;
    assign out_sol   = s_q.o_sol;
    assign out_sof   = s_q.o_sof;
    assign out_pix   = s_q.o_pix;

endmodule

// File: rtl/sec_hcond_chk.sv
module sec_hcond_chk #(
    parameter int CH_W  = 8,
    parameter int N_CH  = 4,
    localparam int PIX_W = CH_W * N_CH
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_lp_en,
    input logic             cfg_rep_en,
    input logic [N_CH-1:0]  mask_ee,
    input logic [N_CH-1:0]  mask_eo,
    input logic [N_CH-1:0]  mask_oe,
    input logic [N_CH-1:0]  mask_oo,
    input logic             in_valid,
    input logic             in_sol,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_sol,
    input logic             out_sof,
    input logic [PIX_W-1:0] out_pix
);
    a_r4_stall_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && cfg_rep_en) |=> !in_ready);

    a_r4_ready_without_doubling: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rep_en |-> in_ready);

    a_r3_second_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rep_en && !in_ready) |=> (out_valid && !out_sol && !out_sof));

    a_r3_copy_identical: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rep_en && !in_ready && (mask_ee | mask_eo | mask_oe | mask_oo) == '0)
        |=> $stable(out_pix));

    a_r2_pass_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_rep_en && !cfg_lp_en && in_valid && in_ready)
        |=> (out_valid && out_sol == $past(in_sol)));

    a_r5_decimate_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_lp_en && !cfg_rep_en && out_valid) |=> !out_valid);

    a_r8_full_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past((&mask_ee) && (&mask_eo) && (&mask_oe) && (&mask_oo)))
        |-> out_pix == '0);
endmodule

bind sec_hcond sec_hcond_chk #(.CH_W(CH_W), .N_CH(N_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_lp_en  (cfg_lp_en),
    .cfg_rep_en (cfg_rep_en),
    .mask_ee    (mask_ee),
    .mask_eo    (mask_eo),
    .mask_oe    (mask_oe),
    .mask_oo    (mask_oo),
    .in_valid   (in_valid),
    .in_sol     (in_sol),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_sol    (out_sol),
    .out_sof    (out_sof),
    .out_pix    (out_pix)
);

// File: tb/sim_sec_hcond.sv
module sim_sec_hcond;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_lp_en, cfg_rep_en;
    logic [3:0]  mask_ee, mask_eo, mask_oe, mask_oo;
    logic        in_valid, in_sol, in_sof;
    logic [31:0] in_pix;
    logic        in_ready, out_valid, out_sol, out_sof;
    logic [31:0] out_pix;

    always #5 clk = ~clk;

    sec_hcond u0 (
        .clk(clk), .rst_n(rst_n), .cfg_lp_en(cfg_lp_en), .cfg_rep_en(cfg_rep_en),
        .mask_ee(mask_ee), .mask_eo(mask_eo), .mask_oe(mask_oe), .mask_oo(mask_oo),
        .in_valid(in_valid), .in_sol(in_sol), .in_sof(in_sof), .in_pix(in_pix),
        .in_ready(in_ready), .out_valid(out_valid), .out_sol(out_sol),
        .out_sof(out_sof), .out_pix(out_pix)
    );

    typedef struct {
        logic [31:0] pix;
        bit          sol;
        bit          sof;
    } ent_t;

    int    n_chk = 0;
    int    n_err = 0;
    ent_t  oq[$];            // accepted, not yet shown
    bit    exp_v = 1'b0;
    bit    exp_sol, exp_sof;
    logic [31:0] exp_pix;
    int    row_i = 0, col_i = 0;
    bit    have_first = 1'b0;
    ent_t  first_e;
    string tag = "R1";
    bit    busy = 1'b0;
    int    g_line, g_col;

    function automatic logic [31:0] avg2(logic [31:0] a, logic [31:0] b);
        logic [31:0] r;
        for (int c = 0; c < 4; c++) r[c*8 +: 8] = 8'((int'(a[c*8 +: 8]) + int'(b[c*8 +: 8]) + 1) / 2);
        return r;
    endfunction

    function automatic logic [31:0] apply_mask(logic [31:0] p, int r, int c);
        logic [3:0] m;
        if (r % 2 == 0) m = (c % 2 == 0) ? mask_ee : mask_eo;
        else            m = (c % 2 == 0) ? mask_oe : mask_oo;
        for (int k = 0; k < 4; k++) if (m[k]) p[k*8 +: 8] = 8'h00;
        return p;
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, expv, $time);
        end
    endtask

    task automatic step(int lines, int len, int dens);
        ent_t e, nx;
        bit   rdy, acc, lp, rp;
        @(negedge clk);
        check(out_valid === exp_v, tag, "out_valid", 32'(out_valid), 32'(exp_v));
        if (exp_v) begin
            check(out_pix === exp_pix, tag, "out_pix", out_pix, exp_pix);
            check(out_sol === exp_sol, tag, "out_sol", 32'(out_sol), 32'(exp_sol));
            check(out_sof === exp_sof, tag, "out_sof", 32'(out_sof), 32'(exp_sof));
        end
        if (!busy) begin
            in_valid = 1'b0;
            if (g_line < lines && $urandom_range(99) < dens) begin
                in_valid = 1'b1;
                in_sof   = (g_line == 0 && g_col == 0);
                in_sol   = (g_col == 0);
                in_pix   = $urandom;
                g_col++;
                if (g_col == len) begin
                    g_col = 0;
                    g_line++;
                end
            end
        end
        #1;
        rp  = cfg_rep_en;
        lp  = cfg_lp_en && !cfg_rep_en;
        rdy = rp ? (oq.size() == 0) : 1'b1;
        check(in_ready === rdy, "R4", "in_ready", 32'(in_ready), 32'(rdy));
        acc = in_valid && rdy;
        if (!lp) have_first = 1'b0;
        if (acc) begin
            nx.pix = in_pix; nx.sol = in_sol; nx.sof = in_sof;
            if (rp) begin
                oq.push_back(nx);
                nx.sol = 1'b0; nx.sof = 1'b0;
                oq.push_back(nx);
            end else if (lp) begin
                if (have_first && !(in_sol || in_sof)) begin
                    e.pix = avg2(first_e.pix, in_pix);
                    e.sol = first_e.sol; e.sof = first_e.sof;
                    oq.push_back(e);
                    have_first = 1'b0;
                end else begin
                    first_e = nx;
                    have_first = 1'b1;
                end
            end else begin
                oq.push_back(nx);
            end
        end
        busy = in_valid && !acc;
        if (oq.size() > 0) begin
            e = oq.pop_front();
            if (e.sof) begin row_i = 0; col_i = 0; end
            else if (e.sol) begin row_i++; col_i = 0; end
            else col_i++;
            exp_v = 1'b1; exp_sol = e.sol; exp_sof = e.sof;
            exp_pix = apply_mask(e.pix, row_i, col_i);
        end else begin
            exp_v = 1'b0;
        end
    endtask

    task automatic run_seg(string t, bit lp, bit rp, logic [3:0] mee, logic [3:0] meo,
                           logic [3:0] moe, logic [3:0] moo, int lines, int len, int dens);
        tag = t;
        cfg_lp_en = lp; cfg_rep_en = rp;
        mask_ee = mee; mask_eo = meo; mask_oe = moe; mask_oo = moo;
        g_line = 0; g_col = 0;
        while (g_line < lines || busy || oq.size() > 0) step(lines, len, dens);
        repeat (4) step(0, 1, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired, run did not finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        cfg_lp_en = 1'b0; cfg_rep_en = 1'b0;
        mask_ee = '0; mask_eo = '0; mask_oe = '0; mask_oo = '0;
        in_valid = 1'b0; in_sol = 1'b0; in_sof = 1'b0; in_pix = '0;
        repeat (2) @(negedge clk);
        // R1: reset values
        check(out_valid === 1'b0, "R1", "out_valid", 32'(out_valid), 32'd0);
        check(out_sol === 1'b0 && out_sof === 1'b0, "R1", "markers", {out_sol, out_sof}, 32'd0);
        check(out_pix === 32'd0, "R1", "out_pix", out_pix, 32'd0);
        check(in_ready === 1'b1, "R1", "in_ready", 32'(in_ready), 32'd1);
        rst_n = 1'b1;

        run_seg("R2", 0, 0, 4'h0, 4'h0, 4'h0, 4'h0, 3, 6, 70);
        run_seg("R2", 0, 0, 4'h0, 4'h0, 4'h0, 4'h0, 2, 7, 100);
        run_seg("R3", 0, 1, 4'h0, 4'h0, 4'h0, 4'h0, 3, 5, 100);
        run_seg("R3", 0, 1, 4'h0, 4'h0, 4'h0, 4'h0, 3, 4, 40);
        run_seg("R5", 1, 0, 4'h0, 4'h0, 4'h0, 4'h0, 3, 8, 100);
        run_seg("R5", 1, 0, 4'h0, 4'h0, 4'h0, 4'h0, 2, 6, 60);
        run_seg("R6", 1, 0, 4'h0, 4'h0, 4'h0, 4'h0, 4, 5, 100);
        run_seg("R6", 1, 0, 4'h0, 4'h0, 4'h0, 4'h0, 3, 1, 80);
        run_seg("R7", 1, 1, 4'h0, 4'h0, 4'h0, 4'h0, 3, 4, 100);
        run_seg("R8", 0, 0, 4'h8, 4'h4, 4'h2, 4'h1, 4, 6, 100);
        run_seg("R8", 0, 0, 4'h5, 4'hA, 4'hF, 4'h3, 3, 5, 70);
        run_seg("R9", 0, 1, 4'h0, 4'hF, 4'h9, 4'h6, 3, 3, 100);
        run_seg("R9", 1, 0, 4'h0, 4'hF, 4'hC, 4'h1, 4, 8, 100);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule